// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the host-facing register file of a two-channel disk controller's bus-master DMA engine. It occupies a 16-byte I/O window that holds one 8-byte slice per channel. Each slice carries a command byte, a status byte and a 32-bit descriptor-table pointer. Host software reaches these registers through a simple request bus: one cycle per access, with a byte offset and a size code.

The block holds the per-channel state and passes it to the transfer engine. The engine receives each channel's command byte, a one-cycle strobe whenever the host writes that byte, and the descriptor-table pointer. The engine in turn sends single-cycle pulses that set the active, error and interrupt flags in the status byte.

The status byte combines three kinds of bit. The active flag belongs to the hardware, the error and interrupt flags are cleared by writing ones, and two capability bits are plain storage. Any command/status access wider than a byte is refused.

Top module: `bmdma_regfile`

## Requirements
- R1: Channel c owns window offsets 8c to 8c+7. Within a slice, +0 is the command byte, +2 is the status byte, and +4..+7 is the table pointer.
- R2: A byte read of slice offset +1 or +3 returns 0x000000FF.
- R3: An access to slice offsets +0..+3 with a size code other than 0 (byte) is refused. A read returns all ones at the access width (size 1 gives 0x0000FFFF, size 2 or 3 gives 0xFFFFFFFF). A write changes no register and raises no strobe.
- R4: A byte write to +0 stores the command byte, which appears on the channel's byte of `eng_cmd`. It also raises that channel's bit of `eng_cmd_stb` for exactly the one cycle after the write.
- R5: Status bits 5 and 6 take the written value on every byte write to +2.
- R6: Status bit 0 (active) ignores host writes. An engine set pulse makes it 1 and a clear pulse makes it 0. If both arrive in the same cycle, the set wins.
- R7: Status bits 1 (error) and 2 (interrupt) clear when 1 is written to them and stay unchanged when 0 is written.
- R8: An engine set pulse for error or interrupt takes priority over a host clear in the same cycle, so the bit ends at 1.
- R9: Status bits 3, 4 and 7 always read 0.
- R10: Table-pointer writes update only the bytes covered by the access, with offset +4 being byte 0, and bits 1:0 always read 0. A read returns the addressed bytes right-justified, with bytes past +7 reading as 0. The pointer is driven on `eng_tbl_addr`.
- R11: Reset clears the command, status and table-pointer registers of every channel to 0.
- R12: Every read request produces `hst_rvalid` together with its data in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access request, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 4 | Byte offset in the window |
| hst_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| hst_wdata | input | 32 | Write data, right-justified |
| hst_rvalid | output | 1 | Read data valid |
| hst_rdata | output | 32 | Read data, right-justified |
| eng_set_act | input | 2 | Per-channel set pulse for the active flag |
| eng_clr_act | input | 2 | Per-channel clear pulse for the active flag |
| eng_set_err | input | 2 | Per-channel set pulse for the error flag |
| eng_set_irq | input | 2 | Per-channel set pulse for the interrupt flag |
| eng_cmd | output | 16 | Command bytes, channel c in bits 8c+7:8c |
| eng_cmd_stb | output | 2 | Per-channel command-write strobe |
| eng_tbl_addr | output | 64 | Table pointers, channel c in bits 32c+31:32c |

## Verification
Two sources can act on the error and interrupt flags in the same cycle: an engine set pulse and a host write-one-to-clear. The bench provokes this by driving the set pulse on the very cycle the status write is presented. It then reads the byte back and expects the pulsed flag at 1 and the other flag cleared. The active flag is tested the same way, with a host write and with simultaneous set and clear pulses, and its read-back must show that the engine's value decides.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    localparam int SLICE_BYTES = 8;
    localparam int SLICE_W     = $clog2(SLICE_BYTES);

    typedef enum logic [1:0] {
        FLD_CMD = 2'd0,
        FLD_PAD = 2'd1,
        FLD_STS = 2'd2,
        FLD_TBL = 2'd3
    } fld_e;

    typedef struct packed {
        logic cap6;
        logic cap5;
        logic irq;
        logic err;
        logic act;
    } sts_t;

    typedef struct packed {
        fld_e       fld;
        logic       refuse;
        logic [1:0] boff;
        logic [3:0] be;
    } dec_t;

    function automatic logic [7:0] sts_pack(input sts_t s);
        return {1'b0, s.cap6, s.cap5, 2'b00, s.irq, s.err, s.act};
    endfunction

    function automatic logic [3:0] size_lanes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] size_ones(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bmr_decode.sv
module bmr_decode
    import bmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CH_W   = $clog2(NCH),
    parameter int ADDR_W = CH_W + SLICE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [CH_W-1:0]   ch,
    output dec_t              dec
);
    logic [SLICE_W-1:0] sub;
    logic [7:0]         lane_wide;

    assign sub       = addr[SLICE_W-1:0];
    assign ch        = addr[ADDR_W-1:SLICE_W];
    assign lane_wide = {4'b0000, size_lanes(size)} << sub[1:0];

    always_comb begin
        dec.boff   = sub[1:0];
        dec.be     = 4'b0000;
        dec.refuse = 1'b0;
        dec.fld    = FLD_PAD;
        if (sub[2]) begin
            dec.fld = FLD_TBL;
            dec.be  = lane_wide[3:0];
        end else begin
            dec.refuse = (size != 2'd0);
            case (sub[1:0])
                2'd0:    dec.fld = FLD_CMD;
                2'd2:    dec.fld = FLD_STS;
                default: dec.fld = FLD_PAD;
            endcase
        end
    end
endmodule

// File: rtl/bmr_chan.sv
module bmr_chan
    import bmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic        sts_we,
    input  logic [3:0]  tbl_be,
    input  logic [1:0]  boff,
    input  logic [31:0] wdata,
    input  logic        set_act,
    input  logic        clr_act,
    input  logic        set_err,
    input  logic        set_irq,
    output logic [7:0]  cmd_q,
    output logic        cmd_stb,
    output logic [7:0]  sts_byte,
    output logic [31:0] tbl_q
);
    sts_t        sts_r;
    logic [31:2] tbl_r;
    logic [1:0]  src0;

    assign src0     = 2'd0 - boff;
    assign sts_byte = sts_pack(sts_r);
    assign tbl_q    = {tbl_r, 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            cmd_stb <= 1'b0;
            sts_r   <= '0;
            tbl_r   <= '0;
        end else begin
            cmd_stb <= cmd_we;
            if (cmd_we) cmd_q <= wdata[7:0];

            if (set_act)      sts_r.act <= 1'b1;
            else if (clr_act) sts_r.act <= 1'b0;

            sts_r.err <= set_err | (sts_r.err & ~(sts_we & wdata[1]));
            sts_r.irq <= set_irq | (sts_r.irq & ~(sts_we & wdata[2]));

            if (sts_we) begin
                sts_r.cap5 <= wdata[5];
                sts_r.cap6 <= wdata[6];
            end

            if (tbl_be[0]) tbl_r[7:2] <= wdata[{src0, 3'b010} +: 6];
            for (int i = 1; i < 4; i++) begin
                if (tbl_be[i]) tbl_r[i*8 +: 8] <= wdata[{2'(i) - boff, 3'b000} +: 8];
            end
        end
    end

    // R6: host write alone never moves the active flag
    p_act_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sts_we && !set_act && !clr_act) |=> (sts_byte[0] == $past(sts_byte[0])));

    // R8: engine set wins over a same-cycle host clear
    p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
        set_err |=> sts_byte[1]);
    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        set_irq |=> sts_byte[2]);

    // R7: writing one clears when no set pulse competes
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_we && wdata[2] && !set_irq) |=> !sts_byte[2]);

    // R4: strobe and stored byte follow a command write
    p_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_we |=> (cmd_stb && cmd_q == $past(wdata[7:0])));
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CH_W   = $clog2(NCH),
    parameter int ADDR_W = CH_W + SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_req,
    input  logic              hst_wr,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [1:0]        hst_size,
    input  logic [31:0]       hst_wdata,
    output logic              hst_rvalid,
    output logic [31:0]       hst_rdata,
    input  logic [NCH-1:0]    eng_set_act,
    input  logic [NCH-1:0]    eng_clr_act,
    input  logic [NCH-1:0]    eng_set_err,
    input  logic [NCH-1:0]    eng_set_irq,
    output logic [NCH*8-1:0]  eng_cmd,
    output logic [NCH-1:0]    eng_cmd_stb,
    output logic [NCH*32-1:0] eng_tbl_addr
);
    logic [CH_W-1:0] dch;
    dec_t            dec;
    logic [7:0]      cmd_a [NCH];
    logic [7:0]      sts_a [NCH];
    logic [31:0]     tbl_a [NCH];
    logic [31:0]     rd_next;

    bmr_decode #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .addr (hst_addr),
        .size (hst_size),
        .ch   (dch),
        .dec  (dec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_hit;
        assign wr_hit = hst_req && hst_wr && (dch == CH_W'(c));

        bmr_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .cmd_we  (wr_hit && !dec.refuse && dec.fld == FLD_CMD),
            .sts_we  (wr_hit && !dec.refuse && dec.fld == FLD_STS),
            .tbl_be  ((wr_hit && dec.fld == FLD_TBL) ? dec.be : 4'b0000),
            .boff    (dec.boff),
            .wdata   (hst_wdata),
            .set_act (eng_set_act[c]),
            .clr_act (eng_clr_act[c]),
            .set_err (eng_set_err[c]),
            .set_irq (eng_set_irq[c]),
            .cmd_q   (cmd_a[c]),
            .cmd_stb (eng_cmd_stb[c]),
            .sts_byte(sts_a[c]),
            .tbl_q   (tbl_a[c])
        );

        assign eng_cmd[c*8 +: 8]       = cmd_a[c];
        assign eng_tbl_addr[c*32 +: 32] = tbl_a[c];
    end

    always_comb begin
        if (dec.refuse) begin
            rd_next = size_ones(hst_size);
        end else begin
            case (dec.fld)
                FLD_CMD: rd_next = {24'h0, cmd_a[dch]};
                FLD_STS: rd_next = {24'h0, sts_a[dch]};
                FLD_TBL: rd_next = (tbl_a[dch] >> {dec.boff, 3'b000}) & size_ones(hst_size);
                default: rd_next = 32'h0000_00FF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rvalid <= 1'b0;
            hst_rdata  <= '0;
        end else begin
            hst_rvalid <= hst_req && !hst_wr;
            if (hst_req && !hst_wr) hst_rdata <= rd_next;
        end
    end

    // R12: one-cycle read latency
    p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
        (hst_req && !hst_wr) |=> hst_rvalid);

    // R3: refused write raises no command strobe
    p_refused_write_r3: assert property (@(posedge clk) disable iff (rst)
        (hst_req && hst_wr && hst_size != 2'd0 && !hst_addr[2]) |=> (eng_cmd_stb == '0));

    // R9: reserved status bits read back as zero
    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (hst_req && !hst_wr && hst_size == 2'd0 && hst_addr[2:0] == 3'd2)
        |=> (hst_rdata[7] == 1'b0 && hst_rdata[4:3] == 2'b00));

    // R10: pointer alignment seen at the engine side
    p_tbl_align_r10: assert property (@(posedge clk) disable iff (rst)
        (hst_req && hst_wr && hst_addr[2:0] == 3'd4) |=> (eng_tbl_addr[1:0] == 2'b00));
endmodule

// File: tb/test_bmdma_regfile.sv
`timescale 1ns/1ps
module test_bmdma_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req = 1'b0, hst_wr = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic [1:0]  hst_size = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_rvalid;
    logic [31:0] hst_rdata;
    logic [1:0]  eng_set_act = '0, eng_clr_act = '0, eng_set_err = '0, eng_set_irq = '0;
    logic [15:0] eng_cmd;
    logic [1:0]  eng_cmd_stb;
    logic [63:0] eng_tbl_addr;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bmdma_regfile i_bmdma_regfile (
        .clk(clk), .rst(rst), .hst_req(hst_req), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_size(hst_size), .hst_wdata(hst_wdata), .hst_rvalid(hst_rvalid),
        .hst_rdata(hst_rdata), .eng_set_act(eng_set_act), .eng_clr_act(eng_clr_act),
        .eng_set_err(eng_set_err), .eng_set_irq(eng_set_irq), .eng_cmd(eng_cmd),
        .eng_cmd_stb(eng_cmd_stb), .eng_tbl_addr(eng_tbl_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        hst_req = 1; hst_wr = 1; hst_addr = a; hst_size = sz; hst_wdata = d;
        @(negedge clk);
        hst_req = 0; hst_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        hst_req = 1; hst_wr = 0; hst_addr = a; hst_size = sz;
        @(negedge clk);
        hst_req = 0;
        chk("R12 rvalid", 64'(hst_rvalid), 64'd1);
        d = hst_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(a, sz, d);
        chk(req, 64'(d), 64'(exp));
    endtask

    task automatic t_reset;
        rd_chk("R11 cmd0", 4'd0, 2'd0, 32'h0);
        rd_chk("R11 sts1", 4'd10, 2'd0, 32'h0);
        rd_chk("R11 tbl0", 4'd4, 2'd2, 32'h0);
        chk("R11 engine outs", {eng_tbl_addr[15:0], eng_cmd, 30'd0, eng_cmd_stb}, 64'h0);
    endtask

    task automatic t_cmd;
        wr(4'd8, 2'd0, 32'h09);
        chk("R4 strobe ch1", 64'(eng_cmd_stb), 64'b10);
        chk("R1 R4 cmd bytes", 64'(eng_cmd), 64'h0900);
        @(negedge clk);
        chk("R4 strobe one cycle", 64'(eng_cmd_stb), 64'b00);
        rd_chk("R1 cmd ch1 readback", 4'd8, 2'd0, 32'h09);
    endtask

    task automatic t_pad;
        rd_chk("R2 ch0 +1", 4'd1, 2'd0, 32'hFF);
        rd_chk("R2 ch0 +3", 4'd3, 2'd0, 32'hFF);
        rd_chk("R2 ch1 +3", 4'd11, 2'd0, 32'hFF);
    endtask

    task automatic t_refuse;
        rd_chk("R3 half read", 4'd0, 2'd1, 32'h0000FFFF);
        rd_chk("R3 dword read", 4'd10, 2'd2, 32'hFFFFFFFF);
        wr(4'd8, 2'd1, 32'h55);
        chk("R3 no strobe", 64'(eng_cmd_stb), 64'b00);
        chk("R3 cmd kept", 64'(eng_cmd), 64'h0900);
        wr(4'd2, 2'd2, 32'h60);
        rd_chk("R3 sts kept", 4'd2, 2'd0, 32'h00);
    endtask

    task automatic t_caps;
        wr(4'd2, 2'd0, 32'hFF);
        rd_chk("R5 R9 caps set, reserved zero", 4'd2, 2'd0, 32'h60);
        wr(4'd2, 2'd0, 32'h20);
        rd_chk("R5 cap6 cleared", 4'd2, 2'd0, 32'h20);
    endtask

    task automatic t_active;
        @(negedge clk); eng_set_act = 2'b01; @(negedge clk); eng_set_act = 2'b00;
        rd_chk("R6 active set", 4'd2, 2'd0, 32'h21);
        wr(4'd2, 2'd0, 32'h00);
        rd_chk("R6 host cannot clear", 4'd2, 2'd0, 32'h01);
        @(negedge clk); eng_clr_act = 2'b01; @(negedge clk); eng_clr_act = 2'b00;
        rd_chk("R6 engine clear", 4'd2, 2'd0, 32'h00);
        wr(4'd2, 2'd0, 32'h01);
        rd_chk("R6 host cannot set", 4'd2, 2'd0, 32'h00);
        @(negedge clk); eng_set_act = 2'b01; eng_clr_act = 2'b01;
        @(negedge clk); eng_set_act = 2'b00; eng_clr_act = 2'b00;
        rd_chk("R6 set beats clear", 4'd2, 2'd0, 32'h01);
        @(negedge clk); eng_clr_act = 2'b01; @(negedge clk); eng_clr_act = 2'b00;
    endtask

    task automatic t_w1c;
        @(negedge clk); eng_set_err = 2'b10; eng_set_irq = 2'b10;
        @(negedge clk); eng_set_err = 2'b00; eng_set_irq = 2'b00;
        rd_chk("R7 both set", 4'd10, 2'd0, 32'h06);
        rd_chk("R7 ch0 untouched", 4'd2, 2'd0, 32'h00);
        wr(4'd10, 2'd0, 32'h00);
        rd_chk("R7 zero keeps", 4'd10, 2'd0, 32'h06);
        wr(4'd10, 2'd0, 32'h02);
        rd_chk("R7 clear err", 4'd10, 2'd0, 32'h04);
        wr(4'd10, 2'd0, 32'h04);
        rd_chk("R7 clear irq", 4'd10, 2'd0, 32'h00);
    endtask

    task automatic t_collide;
        @(negedge clk); eng_set_irq = 2'b01; @(negedge clk); eng_set_irq = 2'b00;
        @(negedge clk);
        hst_req = 1; hst_wr = 1; hst_addr = 4'd2; hst_size = 2'd0; hst_wdata = 32'h06;
        eng_set_err = 2'b01;
        @(negedge clk);
        hst_req = 0; hst_wr = 0; eng_set_err = 2'b00;
        rd_chk("R8 err set wins, irq cleared", 4'd2, 2'd0, 32'h02);
        @(negedge clk);
        hst_req = 1; hst_wr = 1; hst_addr = 4'd2; hst_size = 2'd0; hst_wdata = 32'h04;
        eng_set_irq = 2'b01;
        @(negedge clk);
        hst_req = 0; hst_wr = 0; eng_set_irq = 2'b00;
        rd_chk("R8 irq set wins", 4'd2, 2'd0, 32'h06);
    endtask

    task automatic t_tbl;
        wr(4'd4, 2'd2, 32'h12345677);
        rd_chk("R10 dword, low bits zero", 4'd4, 2'd2, 32'h12345674);
        chk("R10 engine pointer ch0", 64'(eng_tbl_addr[31:0]), 64'h12345674);
        wr(4'd4, 2'd0, 32'hFF);
        rd_chk("R10 byte lane 0", 4'd4, 2'd2, 32'h123456FC);
        rd_chk("R10 half read +6", 4'd6, 2'd1, 32'h1234);
        rd_chk("R10 dword at +7 clipped", 4'd7, 2'd2, 32'h12);
        wr(4'd13, 2'd0, 32'hAB);
        rd_chk("R1 R10 ch1 byte lane 1", 4'd12, 2'd2, 32'h0000AB00);
        chk("R10 engine pointer ch1", 64'(eng_tbl_addr[63:32]), 64'h0000AB00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_cmd();
        t_pad();
        t_refuse();
        t_caps();
        t_active();
        t_w1c();
        t_collide();
        t_tbl();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule